// File: doc/BRIEF.md
# Phase-Gated Triple-Port Register File

This block holds four small general purpose registers for a tiny processor datapath. A single packed command word carries three independent orders: one for the write port, one for operand port A and one for operand port B. Each order has its own enable bit and a register number. The instruction cycle is split into phases. The two read ports present register contents only while the read phase is high. The write port captures the datapath result only while the write phase is high.

An idle read port drives all zeros, so its output can be OR-merged with other sources onto a shared operand line. Reads and writes are gated by different phases. In one instruction, a register can therefore feed both operands in the read phase and take back the result in the write phase. Reading a register onto both operands of an adder and writing the sum back doubles its value on every pass.

Top module: `gp_regfile`

## Requirements
- R1: After a cycle with `rst` high, every register reads back as zero.
- R2: The command word `cmd[8:0]` is split into three fields. Bits [8:6] control the write port, bits [5:3] control read port A, and bits [2:0] control read port B. Within each field, the top bit is the enable and the lower two bits are the register number (0 to 3).
- R3: At a rising clock edge where `ph_wr` is high and the write enable is set, the addressed register takes the value on `res`.
- R4: A read port whose enable is low, or any read port while `ph_rd` is low, drives all zeros.
- R5: While `ph_rd` is high and a read port's enable is set, that port shows the current contents of its addressed register in the same cycle, without waiting for a clock edge.
- R6: No register changes at an edge where `ph_wr` is low or the write enable is clear, whatever the write address and `res` are.
- R7: The write port and both read ports may name the same register. Reading it onto both ports and writing back their sum doubles its value on each pass, modulo 16.
- R8: Ports A and B select their registers independently and may name the same register or different ones.
- R9: If `rst` and an enabled, phase-qualified write occur together, the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_rd | input | 1 | Read phase qualifier |
| ph_wr | input | 1 | Write phase qualifier |
| cmd | input | 9 | Packed write, read A and read B commands |
| res | input | 4 | Datapath result to be written |
| opa | output | 4 | Operand A output, zero when idle |
| opb | output | 4 | Operand B output, zero when idle |

## Verification
The embedded properties check four things on every clock: an idle read port stays at zero, an enabled read port in the read phase shows the addressed register, a qualified write lands in the addressed register, and storage holds steady when no write is qualified. The register-doubling loop needs an external adder and several instruction cycles, so only the bench scenarios can show it. The same holds for the exact bit layout of the command field, reset taking priority over a write, and independent or shared port selection under random phase and command traffic.

// File: rtl/gp_regfile.sv
module gp_regfile #(
  parameter int W = 4,
  parameter int N = 4,
  localparam int AW = $clog2(N),
  localparam int FW = AW + 1,
  localparam int CW = 3 * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph_rd,
  input  logic          ph_wr,
  input  logic [CW-1:0] cmd,
  input  logic [W-1:0]  res,
  output logic [W-1:0]  opa,
  output logic [W-1:0]  opb
);

  logic [FW-1:0] fw, fa, fb;
  assign fw = cmd[3*FW-1 -: FW];
  assign fa = cmd[2*FW-1 -: FW];
  assign fb = cmd[FW-1:0];

  logic          we, ea, eb;
  logic [AW-1:0] wa, aa, ab;
  assign we = fw[AW];
  assign ea = fa[AW];
  assign eb = fb[AW];
  assign wa = fw[AW-1:0];
  assign aa = fa[AW-1:0];
  assign ab = fb[AW-1:0];

  logic [N-1:0] sel_w, sel_a, sel_b;
  logic [N-1:0][W-1:0] mem;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_dec
      assign sel_w[i] = we & ph_wr & (wa == AW'(i));
      assign sel_a[i] = ea & ph_rd & (aa == AW'(i));
      assign sel_b[i] = eb & ph_rd & (ab == AW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (rst) mem[k] <= '0;
      else if (sel_w[k]) mem[k] <= res;
    end
  end

  always_comb begin
    opa = '0;
    opb = '0;
    for (int k = 0; k < N; k++) begin
      opa = opa | (mem[k] & {W{sel_a[k]}});
      opb = opb | (mem[k] & {W{sel_b[k]}});
    end
  end

  a_r4_quiet_a: assert property (@(posedge clk) disable iff (rst)
    !(ph_rd && ea) |-> opa == '0);
  a_r4_quiet_b: assert property (@(posedge clk) disable iff (rst)
    !(ph_rd && eb) |-> opb == '0);
  a_r5_read_a: assert property (@(posedge clk) disable iff (rst)
    (ph_rd && ea) |-> opa == mem[aa]);
  a_r5_read_b: assert property (@(posedge clk) disable iff (rst)
    (ph_rd && eb) |-> opb == mem[ab]);
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (ph_wr && we) |=> mem[$past(wa)] == $past(res));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !(ph_wr && we) |=> $stable(mem));

endmodule

// File: tb/gp_regfile_bench.sv
module gp_regfile_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ph_rd = 1'b0, ph_wr = 1'b0;
  logic [8:0] cmd = '0;
  logic [3:0] res = '0;
  logic [3:0] opa, opb;

  int checks = 0;
  int fails = 0;
  int mdl [4];
  bit done = 1'b0;

  always #4 clk = ~clk;

  gp_regfile u_gp_regfile (
    .clk(clk), .rst(rst), .ph_rd(ph_rd), .ph_wr(ph_wr),
    .cmd(cmd), .res(res), .opa(opa), .opb(opb)
  );

  function automatic int expect_port(input logic [2:0] f);
    if (ph_rd && f[2]) return mdl[f[1:0]];
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare before posedge, update model at posedge.
  task automatic cyc(input logic r, input logic pr, input logic pw,
                     input logic [8:0] c, input logic [3:0] d, input string tag);
    rst = r; ph_rd = pr; ph_wr = pw; cmd = c; res = d;
    #2;
    chk({tag, (pr && c[5]) ? " R5 portA" : " R4 portA"}, int'(opa), expect_port(c[5:3]));
    chk({tag, (pr && c[2]) ? " R5 portB" : " R4 portB"}, int'(opb), expect_port(c[2:0]));
    @(posedge clk);
    if (r) for (int k = 0; k < 4; k++) mdl[k] = 0;
    else if (pw && c[8]) mdl[c[7:6]] = int'(d);
    @(negedge clk);
  endtask

  function automatic logic [8:0] mk(input logic w_en, input int w,
      input logic a_en, input int a, input logic b_en, input int b);
    return {w_en, 2'(w), a_en, 2'(a), b_en, 2'(b)};
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = 0;
    @(negedge clk);
    cyc(1, 0, 0, '0, 4'h0, "R1");
    cyc(1, 0, 0, '0, 4'h0, "R1");
    // R1: every register reads zero after reset
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, mk(0, 0, 1, k, 1, k), 4'h0, "R1");
    // R2/R3: load distinct values through the write field
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, mk(1, k, 0, 0, 0, 0), 4'(k * 5 + 3), "R3");
    // R2/R8: read every pair of registers independently
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) cyc(0, 1, 0, mk(0, 0, 1, a, 1, b), 4'h0, "R8");
    // R6: write phase without enable, and enable without phase
    cyc(0, 0, 1, mk(0, 1, 0, 0, 0, 0), 4'hF, "R6");
    cyc(0, 0, 0, mk(1, 1, 0, 0, 0, 0), 4'hF, "R6");
    cyc(0, 1, 0, mk(0, 0, 1, 1, 0, 0), 4'h0, "R6");
    chk("R6 reg1 held", int'(opa), 8);
    // R4: enables set but no read phase
    cyc(0, 0, 0, mk(0, 0, 1, 2, 1, 3), 4'h0, "R4");
    // R7: doubling loop on register 2
    cyc(0, 0, 1, mk(1, 2, 0, 0, 0, 0), 4'h1, "R7");
    for (int n = 0; n < 5; n++) begin
      int sum;
      cyc(0, 1, 0, mk(1, 2, 1, 2, 1, 2), 4'h0, "R7");
      sum = (int'(opa) + int'(opb)) & 15;
      cyc(0, 0, 1, mk(1, 2, 1, 2, 1, 2), 4'(sum), "R7");
    end
    cyc(0, 1, 0, mk(0, 0, 1, 2, 0, 0), 4'h0, "R7");
    chk("R7 after five doublings", int'(opa), 0);
    // R9: reset beats a qualified write
    cyc(0, 0, 1, mk(1, 3, 0, 0, 0, 0), 4'h9, "R9");
    cyc(1, 0, 1, mk(1, 3, 0, 0, 0, 0), 4'h6, "R9");
    cyc(0, 1, 0, mk(0, 0, 1, 3, 0, 0), 4'h0, "R9");
    chk("R9 reg3 cleared", int'(opa), 0);
    // Random traffic, both phases possibly high together
    for (int n = 0; n < 600; n++)
      cyc(($urandom % 50) == 0, 1'($urandom), 1'($urandom), 9'($urandom), 4'($urandom), "RND");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule